// File: doc/BRIEF.md
# Watchdog Input Conditioner

This block sits in front of a window watchdog's state machine. It takes three asynchronous pins: a trigger line, a mode line and a wake-up line. It turns them into clean, clock-aligned information that the state machine can act on. Each pin first passes through a two-stage synchronizer. It then passes through a counting debouncer, which accepts a new level only after the synchronized value has held steady for a set number of cycles.

The trigger and mode lines use a short debounce interval. The wake-up line uses a much longer one. The block outputs the debounced trigger and mode levels, plus three single-cycle strobes:

- A trigger-accepted strobe after each debounced rising trigger edge.
- A trigger-fault strobe when the debounced trigger stays low for too long.
- A wake strobe on every debounced edge of the wake-up line, rising or falling.

The trigger and mode lines idle high, and the wake-up line idles low.

Top module: `wdg_input_cond`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `trg_lvl_o` and `mode_lvl_o` read 1 and all three strobes read 0. The wake-up line's internal debounced level is 0.
- R2: Suppose a new level on `trg_raw_i` or `mode_raw_i` is first sampled at rising clock edge k and then held. The matching level output takes the new value right after edge k+1+SHORT_DEB, where SHORT_DEB is 4 by default.
- R3: If a raw input returns to the current debounced level before the full debounce count has passed, the debounced output does not change. Any such bounce restarts the count.
- R4: The wake-up line uses the same rule with WAKE_DEB cycles, 112 by default. A level held for fewer cycles produces no wake strobe.
- R5: `wake_edge_o` is high for exactly one cycle after each change of the debounced wake-up level, on both rising and falling changes.
- R6: `trg_ok_o` is high for exactly the one cycle that follows a 0-to-1 change of `trg_lvl_o`, and is low at all other times.
- R7: `trg_err_o` goes high in the cycle in which `trg_lvl_o` has been low for TRG_MAX+1 consecutive cycles. TRG_MAX is 45 by default.
- R8: `trg_err_o` pulses at most once per low period. A low period of exactly TRG_MAX cycles or fewer gives no pulse, and the low-time count restarts from zero at every debounced rising edge.
- R9: The three channels are independent. Activity on one line never changes the level or strobes that belong to another line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trg_raw_i | input | 1 | Raw trigger pin, idles high |
| mode_raw_i | input | 1 | Raw mode pin, high selects long window |
| wake_raw_i | input | 1 | Raw wake-up pin, idles low |
| trg_lvl_o | output | 1 | Debounced trigger level |
| mode_lvl_o | output | 1 | Debounced mode level |
| trg_ok_o | output | 1 | One-cycle strobe after a debounced trigger rise |
| trg_err_o | output | 1 | One-cycle strobe on an over-long trigger low |
| wake_edge_o | output | 1 | One-cycle strobe on any debounced wake-up edge |

## Verification
The trigger is driven with several kinds of low pulse:

- Clean pulses well inside the limit, which check the accept strobe and the latency.
- Pulses of exactly TRG_MAX and TRG_MAX+1 cycles, which separate a compliant pulse from a fault at the boundary.
- A very long low, which shows that the fault strobe fires only once.

Glitches shorter than the debounce count, and bursts of bounces, show that the count restarts instead of accumulating. On the wake-up line, a pulse shorter than WAKE_DEB is set against a held one, which shows the long interval and the two-sided edge strobe. A final phase of random, sparse toggling on all three lines mixes the channels and shows that they do not interfere with each other.

// File: rtl/wdg_input_cond.sv
module wdg_input_cond #(
  parameter int SHORT_DEB = 4,
  parameter int WAKE_DEB  = 112,
  parameter int TRG_MAX   = 45
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trg_raw_i,
  input  logic mode_raw_i,
  input  logic wake_raw_i,
  output logic trg_lvl_o,
  output logic mode_lvl_o,
  output logic trg_ok_o,
  output logic trg_err_o,
  output logic wake_edge_o
);

  localparam int          NCH    = 3;
  localparam int          MAXDEB = (WAKE_DEB > SHORT_DEB) ? WAKE_DEB : SHORT_DEB;
  localparam int          CW     = $clog2(MAXDEB) + 1;
  localparam int          LW     = $clog2(TRG_MAX + 2) + 1;
  localparam logic [NCH-1:0] IDLE = 3'b011;

  logic [NCH-1:0] raw, s1, s2, deb, deb_q;
  logic [LW-1:0]  low_cnt;

  assign raw = {wake_raw_i, mode_raw_i, trg_raw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1    <= IDLE;
      s2    <= IDLE;
      deb_q <= IDLE;
    end else begin
      s1    <= raw;
      s2    <= s1;
      deb_q <= deb;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_deb
    localparam int LEN = (c == 2) ? WAKE_DEB : SHORT_DEB;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt    <= '0;
        deb[c] <= IDLE[c];
      end else if (s2[c] == deb[c]) begin
        cnt <= '0;
      end else if (cnt == CW'(LEN - 1)) begin
        cnt    <= '0;
        deb[c] <= s2[c];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        low_cnt <= '0;
    else if (deb[0])                    low_cnt <= '0;
    else if (low_cnt != LW'(TRG_MAX + 1)) low_cnt <= low_cnt + 1'b1;
  end

  assign trg_lvl_o   = deb[0];
  assign mode_lvl_o  = deb[1];
  assign trg_ok_o    = deb[0] & ~deb_q[0];
  assign wake_edge_o = deb[2] ^ deb_q[2];
  assign trg_err_o   = ~deb[0] & (low_cnt == LW'(TRG_MAX));

endmodule

// File: rtl/wdg_input_cond_chk.sv
module wdg_input_cond_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trg_sync,
  input logic mode_sync,
  input logic trg_lvl,
  input logic mode_lvl,
  input logic trg_ok,
  input logic trg_err,
  input logic wake_edge
);

  AST_RESET_IDLE: assert property (@(posedge clk_i) !rst_ni |=> (trg_lvl && mode_lvl && !trg_ok && !trg_err && !wake_edge)); // R1
  AST_TRG_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(trg_lvl) |-> $past(trg_sync) == trg_lvl); // R3
  AST_MODE_FOLLOWS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(mode_lvl) |-> $past(mode_sync) == mode_lvl); // R3
  AST_OK_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(trg_lvl) |-> trg_ok); // R6
  AST_OK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) trg_ok |=> !trg_ok); // R6
  AST_ERR_WHILE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni) trg_err |-> !trg_lvl && $past(!trg_lvl)); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) trg_err |=> !trg_err); // R8
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) wake_edge |=> !wake_edge); // R5

endmodule

bind wdg_input_cond wdg_input_cond_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trg_sync  (s2[0]),
  .mode_sync (s2[1]),
  .trg_lvl   (trg_lvl_o),
  .mode_lvl  (mode_lvl_o),
  .trg_ok    (trg_ok_o),
  .trg_err   (trg_err_o),
  .wake_edge (wake_edge_o)
);

// File: tb/wdg_input_cond_tb.sv
`timescale 1ns/1ps
module wdg_input_cond_tb;
  localparam int SHORT_DEB = 4;
  localparam int WAKE_DEB  = 112;
  localparam int TRG_MAX   = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trg = 1'b1, mode = 1'b1, wake = 1'b0;
  logic trg_lvl, mode_lvl, trg_ok, trg_err, wake_edge;
  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdg_input_cond #(.SHORT_DEB(SHORT_DEB), .WAKE_DEB(WAKE_DEB), .TRG_MAX(TRG_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trg_raw_i(trg), .mode_raw_i(mode), .wake_raw_i(wake),
    .trg_lvl_o(trg_lvl), .mode_lvl_o(mode_lvl), .trg_ok_o(trg_ok),
    .trg_err_o(trg_err), .wake_edge_o(wake_edge));

  // reference model: per-line history of synchronized samples and run lengths
  int m_sync[3][$];
  int m_lvl[3], m_run[3];
  int low_run;
  bit e_ok, e_err, e_wake;

  function automatic int deb_len(int c);
    return (c == 2) ? WAKE_DEB : SHORT_DEB;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        m_sync[c] = '{(c == 2) ? 0 : 1, (c == 2) ? 0 : 1};
        m_lvl[c] = (c == 2) ? 0 : 1;
        m_run[c] = 0;
      end
      low_run = 0; e_ok = 0; e_err = 0; e_wake = 0;
    end else begin
      int prev[3];
      for (int c = 0; c < 3; c++) begin
        prev[c] = m_lvl[c];
        if (m_sync[c][0] == m_lvl[c]) m_run[c] = 0;
        else begin
          m_run[c]++;
          if (m_run[c] == deb_len(c)) begin m_lvl[c] = m_sync[c][0]; m_run[c] = 0; end
        end
      end
      m_sync[0].push_back(int'(trg));  void'(m_sync[0].pop_front());
      m_sync[1].push_back(int'(mode)); void'(m_sync[1].pop_front());
      m_sync[2].push_back(int'(wake)); void'(m_sync[2].pop_front());
      e_ok   = (m_lvl[0] == 1) && (prev[0] == 0);
      e_wake = (m_lvl[2] != prev[2]);
      low_run = (m_lvl[0] == 0) ? low_run + 1 : 0;
      e_err  = (low_run == TRG_MAX + 1);
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at t=%0t: got %b expected %b", req, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      chk("R2 R3 R9", "trg_lvl",  trg_lvl,  logic'(m_lvl[0]));
      chk("R2 R3 R9", "mode_lvl", mode_lvl, logic'(m_lvl[1]));
      chk("R6",       "trg_ok",   trg_ok,   e_ok);
      chk("R7 R8",    "trg_err",  trg_err,  e_err);
      chk("R4 R5",    "wake_edge", wake_edge, e_wake);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trg_low(int n);
    trg = 1'b0; wait_n(n); trg = 1'b1; wait_n(20);
  endtask

  initial begin
    wait_n(3);
    vectors++;  // R1: reset levels
    chk("R1", "reset trg_lvl", trg_lvl, 1'b1);
    chk("R1", "reset mode_lvl", mode_lvl, 1'b1);
    chk("R1", "reset strobes", trg_ok | trg_err | wake_edge, 1'b0);
    trg = 1'b0; wake = 1'b1; mode = 1'b0; wait_n(2);  // ignored under reset
    trg = 1'b1; wake = 1'b0; mode = 1'b1;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
    vectors++;
    chk("R1", "post-reset trg_lvl", trg_lvl, 1'b1);
    wait_n(10);

    trg_low(10);                 // R6 clean pulse
    trg_low(2); trg_low(3);      // R3 glitches shorter than debounce
    trg_low(TRG_MAX);            // R8 boundary, no error
    trg_low(TRG_MAX + 1);        // R7 just over
    trg_low(300);                // R8 single error on long low
    for (int i = 0; i < 5; i++) begin trg = 1'b0; wait_n(3); trg = 1'b1; wait_n(1); end  // R3 bounce burst
    trg = 1'b0; wait_n(30); trg = 1'b1; wait_n(20);

    mode = 1'b0; wait_n(3); mode = 1'b1; wait_n(10);    // R3
    mode = 1'b0; wait_n(40); mode = 1'b1; wait_n(10);   // R2
    wake = 1'b1; wait_n(50); wake = 1'b0; wait_n(200);  // R4 short ignored
    wake = 1'b1; wait_n(WAKE_DEB - 1); wake = 1'b0; wait_n(200);  // R4 one short
    wake = 1'b1; wait_n(300); wake = 1'b0; wait_n(300); // R5 both edges
    for (int i = 0; i < 4; i++) begin wake = ~wake; wait_n(60); end  // R4 restart
    wake = 1'b0; wait_n(300);

    for (int i = 0; i < 20000; i++) begin  // R9 mixed random activity
      if ($urandom_range(0, 9) == 0) trg = ~trg;
      if ($urandom_range(0, 19) == 0) mode = ~mode;
      if ($urandom_range(0, 149) == 0) wake = ~wake;
      if ($urandom_range(0, 999) == 0) begin trg = 1'b0; wait_n(60); end
      wait_n(1);
    end
    trg = 1'b1; mode = 1'b1; wake = 1'b0; wait_n(300);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule